// File: doc/BRIEF.md
# Floppy Controller Board Bus Decoder

This block is the address and strobe decoder that sits between an 8-bit microcontroller with an E-clock bus phase and three devices on a floppy-controller board: a disk-controller chip, a 4 KB ROM and a 1 KB SRAM. It looks only at the six upper address bits (A15 down to A10) and the E phase. It produces a two-bit register index, a chip select and separate read and write strobes for the disk controller. It also produces an output enable for the ROM, and a chip enable and a write enable for the SRAM. All of these outputs are active low.

The CPU read/write line reaches the block but does not take part in the decode. Address bit A12 sets the transfer direction instead. As a result, the controller and the SRAM each appear at one address for reading and at another for writing. For example, controller status is read at 0x0800 and commands are written at 0x1800. The SRAM is written through 0x0400 and read through 0x1400.

The controller write strobe is held back until a fixed time has passed since E rose. A counter clocked by the fast system clock measures this time, in place of an analog one-shot. E is first passed through a two-flop synchronizer before it reaches the counter.

Top module: `fdc_bus_glue`

## Requirements
- R1: `fdc_idx` equals {A14, A13}: A13 drives bit 0 and A14 drives bit 1, whatever the other inputs are.
- R2: `fdc_cs_n` is low exactly when A11 = 1 and A15 = 0.
- R3: `fdc_re_n` is low exactly when A12 = 0, E = 1 and A15 = 0.
- R4: `fdc_we_n` goes low only while the synchronized E is high, A12 = 1 and the delay counter has reached TERM = ceil(DELAY_PS / CLK_PERIOD_PS). After E rises with A12 = 1, it first reads low after the (TERM+2)-th rising clock edge. If A12 rises after the delay has elapsed, it goes low at once, with no clock edge needed.
- R5: After E falls, `fdc_we_n` returns high on the second rising edge, which is the cycle in which the synchronized E is first low. The counter restarts from zero.
- R6: While A12 = 0, `fdc_we_n` stays high no matter how long E is held high.
- R7: `rom_oe_n` is low exactly when A15 = 1 and E = 1. A12, A13 and A14 have no effect on it, so the ROM image repeats across 0x8000–0xFFFF.
- R8: `ram_ce_n` is low exactly when A10 = 1, E = 1 and A15 = 0. `ram_we_n` is low exactly when A12 = 0.
- R9: The CPU read/write input has no effect on any output.
- R10: When A10 = A11 = 1 and A15 = 0 with E high, the SRAM and the controller are both selected together. This overlap is kept on purpose.
- R11: Synchronous active-high reset clears the synchronizer and the counter, so `fdc_we_n` is high in the cycle after reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Fast system clock for the synchronizer and the delay counter |
| rst | input | 1 | Synchronous reset, active high |
| addr_hi | input | 6 | Address bits A15..A10 (bit 5 = A15, bit 0 = A10) |
| e_phase | input | 1 | CPU E phase, asynchronous to clk |
| cpu_rw | input | 1 | CPU read/write line, ignored |
| fdc_idx | output | 2 | Controller register index {A14, A13} |
| fdc_cs_n | output | 1 | Controller chip select, active low |
| fdc_re_n | output | 1 | Controller read strobe, active low |
| fdc_we_n | output | 1 | Controller write strobe after the delay, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| ram_ce_n | output | 1 | SRAM chip enable, active low |
| ram_we_n | output | 1 | SRAM write enable, active low |

## Verification
The combinational decode is swept over all 256 combinations of the six address bits, E and the read/write line. The expected outputs are computed bit by bit, which separates each select's own address terms from the bits it must ignore. Sweeping the read/write line shows that it has no effect, and the sweep includes the overlap addresses where two devices are selected together.

The write strobe is tried with four patterns:
- A long E pulse with A12 = 1, sampled one edge before and one edge after the expected TERM+2 point.
- The same pulse with A12 = 0, which must keep the strobe high.
- A12 raised after the delay has elapsed, which must assert the strobe at once.
- A reset during an asserted strobe.

// File: rtl/fdc_bus_glue_pkg.sv
package fdc_bus_glue_pkg;

    typedef struct packed {
        logic a15;
        logic a14;
        logic a13;
        logic a12;
        logic a11;
        logic a10;
    } glue_addr_t;

    typedef struct packed {
        logic [1:0] idx;
        logic       cs_n;
        logic       re_n;
        logic       rom_oe_n;
        logic       ram_ce_n;
        logic       ram_we_n;
    } glue_strobes_t;

    function automatic int unsigned ceil_div(input int unsigned num, input int unsigned den);
        return (num + den - 1) / den;
    endfunction

endpackage

// File: rtl/fdc_addr_decode.sv
module fdc_addr_decode
    import fdc_bus_glue_pkg::*;
(
    input  glue_addr_t    addr,
    input  logic          e_phase,
    output glue_strobes_t strobes
);

    always_comb begin
        strobes.idx      = {addr.a14, addr.a13};
        strobes.cs_n     = ~(addr.a11 & ~addr.a15);
        strobes.re_n     = ~(~addr.a12 & e_phase & ~addr.a15);
        strobes.rom_oe_n = ~(addr.a15 & e_phase);
        strobes.ram_ce_n = ~(addr.a10 & e_phase & ~addr.a15);
        strobes.ram_we_n = addr.a12;
    end

endmodule

// File: rtl/fdc_e_sync.sv
module fdc_e_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic d_async,
    output logic q_sync
);

    logic [STAGES-1:0] chain;

    generate
        if (STAGES == 1) begin : g_single
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= d_async;
            end
        end else begin : g_multi
            always_ff @(posedge clk) begin
                if (rst) chain <= '0;
                else     chain <= {chain[STAGES-2:0], d_async};
            end
        end
    endgenerate

    assign q_sync = chain[STAGES-1];

endmodule

// File: rtl/fdc_wr_delay.sv
module fdc_wr_delay #(
    parameter int TERM = 80
) (
    input  logic clk,
    input  logic rst,
    input  logic e_sync,
    output logic elapsed
);

    localparam int CW = $clog2(TERM + 1);
    localparam logic [CW-1:0] TERM_C = CW'(TERM);

    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || !e_sync)     cnt <= '0;
        else if (cnt != TERM_C) cnt <= cnt + 1'b1;
    end

    assign elapsed = (cnt == TERM_C);

    assert_cnt_bound_R4: assert property (@(posedge clk) disable iff (rst)
        cnt <= TERM_C);

    assert_cnt_clear_R5: assert property (@(posedge clk) disable iff (rst)
        !e_sync |=> (cnt == '0));

endmodule

// File: rtl/fdc_bus_glue.sv
module fdc_bus_glue
    import fdc_bus_glue_pkg::*;
#(
    parameter int CLK_PERIOD_PS = 5000,
    parameter int DELAY_PS      = 400000,
    parameter int SYNC_STAGES   = 2
) (
    input  logic       clk,
    input  logic       rst,
    input  logic [5:0] addr_hi,
    input  logic       e_phase,
    input  logic       cpu_rw,
    output logic [1:0] fdc_idx,
    output logic       fdc_cs_n,
    output logic       fdc_re_n,
    output logic       fdc_we_n,
    output logic       rom_oe_n,
    output logic       ram_ce_n,
    output logic       ram_we_n
);

    localparam int TERM = int'(ceil_div(DELAY_PS, CLK_PERIOD_PS));

    glue_addr_t    addr;
    glue_strobes_t strobes;
    logic          e_s;
    logic          elapsed;

    assign addr = glue_addr_t'(addr_hi);

    fdc_addr_decode u_decode (
        .addr    (addr),
        .e_phase (e_phase),
        .strobes (strobes)
    );

    fdc_e_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (e_phase),
        .q_sync  (e_s)
    );

    fdc_wr_delay #(.TERM(TERM)) u_delay (
        .clk     (clk),
        .rst     (rst),
        .e_sync  (e_s),
        .elapsed (elapsed)
    );

    assign fdc_idx  = strobes.idx;
    assign fdc_cs_n = strobes.cs_n;
    assign fdc_re_n = strobes.re_n;
    assign rom_oe_n = strobes.rom_oe_n;
    assign ram_ce_n = strobes.ram_ce_n;
    assign ram_we_n = strobes.ram_we_n;
    assign fdc_we_n = ~(e_s & addr.a12 & elapsed);

    assert_we_needs_e_R4: assert property (@(posedge clk) disable iff (rst)
        !fdc_we_n |-> $past(e_phase, SYNC_STAGES));

    assert_we_a12_gate_R6: assert property (@(posedge clk) disable iff (rst)
        !addr_hi[2] |-> fdc_we_n);

    assert_rw_ignored_R9: assert property (@(posedge clk) disable iff (rst)
        ($changed(cpu_rw) && $stable(addr_hi) && $stable(e_phase))
        |-> $stable({fdc_idx, fdc_cs_n, fdc_re_n, rom_oe_n, ram_ce_n, ram_we_n}));

    assert_overlap_R10: assert property (@(posedge clk) disable iff (rst)
        (addr_hi[0] && addr_hi[1] && !addr_hi[5] && e_phase) |-> (!ram_ce_n && !fdc_cs_n));

    assert_reset_idle_R11: assert property (@(posedge clk)
        rst |=> fdc_we_n);

endmodule

// File: tb/fdc_bus_glue_tb.sv
module fdc_bus_glue_tb;

    localparam int CLK_PS   = 5000;
    localparam int DELAY_PS = 400000;
    localparam int TERM     = (DELAY_PS + CLK_PS - 1) / CLK_PS;

    logic       clk = 1'b0;
    logic       rst;
    logic [5:0] addr_hi;
    logic       e_phase;
    logic       cpu_rw;
    logic [1:0] fdc_idx;
    logic       fdc_cs_n, fdc_re_n, fdc_we_n, rom_oe_n, ram_ce_n, ram_we_n;

    int checks   = 0;
    int failures = 0;
    bit done     = 1'b0;

    always #2500ps clk = ~clk;

    fdc_bus_glue #(.CLK_PERIOD_PS(CLK_PS), .DELAY_PS(DELAY_PS)) u_dut (
        .clk(clk), .rst(rst), .addr_hi(addr_hi), .e_phase(e_phase), .cpu_rw(cpu_rw),
        .fdc_idx(fdc_idx), .fdc_cs_n(fdc_cs_n), .fdc_re_n(fdc_re_n), .fdc_we_n(fdc_we_n),
        .rom_oe_n(rom_oe_n), .ram_ce_n(ram_ce_n), .ram_we_n(ram_we_n)
    );

    task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic tick;
        @(posedge clk);
        #1;
    endtask

    initial begin
        #(200000 * 5ns);
        if (!done) begin
            failures++;
            $display("FAIL watchdog expired");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; addr_hi = '0; e_phase = 1'b0; cpu_rw = 1'b1;
        repeat (3) tick();
        // R11: reset state of the delayed write strobe
        check("R11 reset idle", {7'b0, fdc_we_n}, 8'h01);
        rst = 1'b0;
        tick();

        // R1 R2 R3 R7 R8 R9 R10: exhaustive combinational sweep
        for (int v = 0; v < 256; v++) begin
            logic a10, a11, a12, a13, a14, a15, e;
            logic [7:0] exp, act;
            addr_hi = v[5:0];
            e_phase = v[6];
            cpu_rw  = v[7];
            #1;
            {a15, a14, a13, a12, a11, a10} = v[5:0];
            e   = v[6];
            exp = {1'b0, a14, a13, ~(a11 & ~a15), ~(~a12 & e & ~a15),
                   ~(a15 & e), ~(a10 & e & ~a15), a12};
            act = {1'b0, fdc_idx, fdc_cs_n, fdc_re_n, rom_oe_n, ram_ce_n, ram_we_n};
            check("R1/R2/R3/R7/R8/R9 sweep", act, exp);
            if (a10 && a11 && !a15 && e)
                check("R10 overlap", {6'b0, ram_ce_n, fdc_cs_n}, 8'h00);
            #1;
        end

        // Settle with E low so the counter is cleared
        e_phase = 1'b0; cpu_rw = 1'b0;
        repeat (4) tick();

        // R4: write to 0x3800, strobe appears after TERM+2 edges
        addr_hi = 6'b001110;
        e_phase = 1'b1;
        for (int k = 1; k <= TERM + 2; k++) begin
            tick();
            if (k == TERM + 1) check("R4 before delay", {7'b0, fdc_we_n}, 8'h01);
            if (k == TERM + 2) check("R4 after delay",  {7'b0, fdc_we_n}, 8'h00);
        end

        // R5: release two edges after E falls
        e_phase = 1'b0;
        tick();
        check("R5 one edge after fall", {7'b0, fdc_we_n}, 8'h00);
        tick();
        check("R5 two edges after fall", {7'b0, fdc_we_n}, 8'h01);
        repeat (2) tick();

        // R6: A12 low (0x2800) with a long E, strobe never asserts
        begin
            logic seen_low;
            seen_low = 1'b0;
            addr_hi  = 6'b001010;
            e_phase  = 1'b1;
            for (int k = 0; k < TERM + 10; k++) begin
                tick();
                if (!fdc_we_n) seen_low = 1'b1;
            end
            check("R6 A12 low blocks strobe", {7'b0, seen_low}, 8'h00);
        end

        // R4: raising A12 after the delay asserts at once
        addr_hi = 6'b001110;
        #1;
        check("R4 immediate after delay", {7'b0, fdc_we_n}, 8'h00);

        // R11: reset during an active strobe
        rst = 1'b1;
        tick();
        check("R11 reset clears strobe", {7'b0, fdc_we_n}, 8'h01);
        rst = 1'b0;
        tick();
        check("R11 restarts after reset", {7'b0, fdc_we_n}, 8'h01);
        e_phase = 1'b0;
        repeat (3) tick();

        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule